// File: doc/BRIEF.md
# Shadow-Memory Store/Recall Controller

This block fronts a working SRAM array and a nonvolatile shadow array of equal depth, both modelled inside it as small arrays with clocked writes and combinational reads. While idle, a host reads and writes the working array through a simple one-cycle port. A store request copies the whole working array into the shadow array. A recall request first zeroes every working location and then loads the shadow contents back into it.

While a store or recall runs, the block raises a busy flag, drives host read data to zero, ignores host writes and drops any new request. Busy lasts for at least a parameterised minimum number of cycles, even when the copy loop finishes earlier. A low-voltage input blocks host writes and refuses store requests. Recall is still accepted while it is active.

Top module: `shadow_store_recall`

## Requirements
- R1: After reset, busy_o is 0 and every working and shadow location holds zero, so host reads of any address return 0.
- R2: When busy_o is 0 and low_volt_i is 0, a host write with host_we_i=1 updates the addressed working location at the clock edge. host_rdata_o shows the working location at host_addr_i combinationally.
- R3: A store request accepted while idle raises busy_o from the next cycle. The block then copies working location k to shadow location k, one address per clock, from address 0 to DEPTH-1.
- R4: Busy stays high for max(MIN_BUSY, DEPTH+1) cycles for a store and for max(MIN_BUSY, 2*DEPTH+1) cycles for a recall.
- R5: While busy_o is 1, host_rdata_o is 0 and host writes have no effect on the working array.
- R6: A recall first clears all working locations in address order and only afterwards copies every shadow location into the working location with the same address.
- R7: A recall leaves the shadow array unchanged, so repeated recalls restore identical contents.
- R8: While low_volt_i is 1, host writes are ignored and a store request is refused: busy_o stays 0 and the shadow array keeps its contents.
- R9: A recall request is accepted while low_volt_i is 1.
- R10: A store or recall request that arrives while busy_o is 1 is dropped and does not start another operation later.
- R11: When store_req_i and recall_req_i are both high in an idle cycle with low_volt_i at 0, the store runs and the recall is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| host_we_i | input | 1 | Host write enable |
| host_addr_i | input | ADDR_W | Host address |
| host_wdata_i | input | DATA_W | Host write data |
| host_rdata_o | output | DATA_W | Host read data, 0 while busy |
| store_req_i | input | 1 | Request copy of working array into shadow |
| recall_req_i | input | 1 | Request clear and reload of working array from shadow |
| low_volt_i | input | 1 | Supply-low flag, blocks writes and store |
| busy_o | output | 1 | Store or recall in progress |

## Verification
A wrong sequencer state shows up first in the length of the busy window, which is checked to the exact cycle. A wrong copy or clear address shows up on the next recall as one or more mismatched words, and every address is read back after each operation. Writes or requests that leak through during busy or low voltage appear as changed words in the next full-array sweep, or as a second busy window right after the first one ends.

// File: rtl/shadow_ctrl_pkg.sv
package shadow_ctrl_pkg;
  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_STORE,
    SEQ_CLEAR,
    SEQ_LOAD,
    SEQ_HOLD
  } seq_state_e;
endpackage

// File: rtl/shadow_ram_array.sv
module shadow_ram_array #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/shadow_seq.sv
module shadow_seq
  import shadow_ctrl_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int MIN_BUSY = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              store_req_i,
  input  logic              recall_req_i,
  input  logic              low_volt_i,
  output logic              busy_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              shd_we_o,
  output logic              wrk_clr_o,
  output logic              wrk_load_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);
  localparam int CNT_W = (MIN_BUSY > 2) ? $clog2(MIN_BUSY) : 1;
  localparam logic [CNT_W-1:0] TMR_MAX = CNT_W'(MIN_BUSY - 1);

  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CNT_W-1:0]  tmr_q, tmr_d;
  logic              go_store, go_recall;

  // store wins a tie; a refused store lets a recall through
  assign go_store  = (state_q == SEQ_IDLE) && store_req_i && !low_volt_i;
  assign go_recall = (state_q == SEQ_IDLE) && recall_req_i && !go_store;

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q + ADDR_W'(1);
    tmr_d   = (tmr_q == TMR_MAX) ? tmr_q : tmr_q + CNT_W'(1);
    unique case (state_q)
      SEQ_IDLE: begin
        addr_d = '0;
        tmr_d  = '0;
        if (go_store)       state_d = SEQ_STORE;
        else if (go_recall) state_d = SEQ_CLEAR;
      end
      SEQ_STORE: if (addr_q == LAST) state_d = SEQ_HOLD;
      SEQ_CLEAR: if (addr_q == LAST) state_d = SEQ_LOAD;
      SEQ_LOAD:  if (addr_q == LAST) state_d = SEQ_HOLD;
      SEQ_HOLD: begin
        addr_d = '0;
        if (tmr_q == TMR_MAX) state_d = SEQ_IDLE;
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      addr_q  <= '0;
      tmr_q   <= '0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      tmr_q   <= tmr_d;
    end
  end

  assign busy_o     = (state_q != SEQ_IDLE);
  assign addr_o     = addr_q;
  assign shd_we_o   = (state_q == SEQ_STORE);
  assign wrk_clr_o  = (state_q == SEQ_CLEAR);
  assign wrk_load_o = (state_q == SEQ_LOAD);

  a_r3_store_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEQ_IDLE && store_req_i && !low_volt_i) |=> (state_q == SEQ_STORE && addr_q == '0));

  a_r8_store_refused: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEQ_IDLE && store_req_i && low_volt_i) |=> (state_q != SEQ_STORE));

  a_r6_clear_then_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_q == SEQ_LOAD) |-> ($past(state_q) == SEQ_CLEAR && $past(addr_q) == LAST));

  a_r3_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == SEQ_STORE || state_q == SEQ_CLEAR || state_q == SEQ_LOAD) && $past(state_q) == state_q)
      |-> (addr_q - $past(addr_q) == ADDR_W'(1)));

  a_r4_min_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> ($past(tmr_q) == TMR_MAX));

  a_r10_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEQ_STORE) |=> (state_q == SEQ_STORE || state_q == SEQ_HOLD));
endmodule

// File: rtl/shadow_store_recall.sv
module shadow_store_recall #(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 8,
  parameter int MIN_BUSY = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_we_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  output logic [DATA_W-1:0] host_rdata_o,
  input  logic              store_req_i,
  input  logic              recall_req_i,
  input  logic              low_volt_i,
  output logic              busy_o
);
  logic              busy;
  logic [ADDR_W-1:0] seq_addr;
  logic              seq_shd_we, seq_clr, seq_load;
  logic              wrk_we, host_wr;
  logic [ADDR_W-1:0] wrk_addr;
  logic [DATA_W-1:0] wrk_wdata, wrk_rdata, shd_rdata;

  shadow_seq #(.ADDR_W(ADDR_W), .MIN_BUSY(MIN_BUSY)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .store_req_i (store_req_i),
    .recall_req_i(recall_req_i),
    .low_volt_i  (low_volt_i),
    .busy_o      (busy),
    .addr_o      (seq_addr),
    .shd_we_o    (seq_shd_we),
    .wrk_clr_o   (seq_clr),
    .wrk_load_o  (seq_load)
  );

  assign host_wr   = host_we_i && !busy && !low_volt_i;
  assign wrk_we    = host_wr || seq_clr || seq_load;
  assign wrk_addr  = busy ? seq_addr : host_addr_i;
  assign wrk_wdata = seq_load ? shd_rdata : (seq_clr ? '0 : host_wdata_i);

  shadow_ram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_work (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wrk_we),
    .waddr_i(wrk_addr),
    .wdata_i(wrk_wdata),
    .raddr_i(wrk_addr),
    .rdata_o(wrk_rdata)
  );

  shadow_ram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_shadow (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (seq_shd_we),
    .waddr_i(seq_addr),
    .wdata_i(wrk_rdata),
    .raddr_i(seq_addr),
    .rdata_o(shd_rdata)
  );

  assign host_rdata_o = busy ? '0 : wrk_rdata;
  assign busy_o       = busy;

  a_r3_shadow_only_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_shd_we |-> busy_o);

  a_r7_recall_keeps_shadow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_clr || seq_load) |-> !seq_shd_we);

  a_r5_no_host_write_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && wrk_we) |-> (seq_clr || seq_load));

  a_r8_low_volt_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (low_volt_i && !busy_o) |-> !wrk_we);
endmodule

// File: tb/shadow_store_recall_tb.sv
module shadow_store_recall_tb;
  localparam int ADDR_W   = 4;
  localparam int DATA_W   = 8;
  localparam int MIN_BUSY = 24;
  localparam int DEPTH    = 1 << ADDR_W;
  localparam int STORE_LEN  = (MIN_BUSY > DEPTH + 1) ? MIN_BUSY : DEPTH + 1;
  localparam int RECALL_LEN = (MIN_BUSY > 2 * DEPTH + 1) ? MIN_BUSY : 2 * DEPTH + 1;

  logic              clk = 0;
  logic              rst_n = 0;
  logic              we = 0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic              store_req = 0, recall_req = 0, low_volt = 0;
  logic              busy;

  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  shadow_store_recall #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MIN_BUSY(MIN_BUSY)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .host_we_i(we), .host_addr_i(addr),
    .host_wdata_i(wdata), .host_rdata_o(rdata), .store_req_i(store_req),
    .recall_req_i(recall_req), .low_volt_i(low_volt), .busy_o(busy)
  );

  function automatic logic [DATA_W-1:0] pat(input int k, input int a);
    return DATA_W'(a * (7 + 2 * k) + 3 + 40 * k);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_all(input int k);
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk);
      we = 1; addr = ADDR_W'(a); wdata = pat(k, a);
    end
    @(negedge clk);
    we = 0;
  endtask

  task automatic read_all(input string req, input int k, input bit zero);
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk);
      addr = ADDR_W'(a);
      #1;
      chk(req, int'(rdata), zero ? 0 : int'(pat(k, a)));
    end
  endtask

  // pulse request(s), then count busy cycles; poke=1 tries a write and a recall mid-run
  task automatic run_op(input bit s, input bit r, input bit poke, output int len);
    @(negedge clk);
    store_req = s; recall_req = r;
    @(negedge clk);
    store_req = 0; recall_req = 0;
    len = 0;
    while (busy && len < 1000) begin
      len++;
      if (poke && len == 2) begin
        addr = ADDR_W'(3);
        #1;
        chk("R5 rdata zero while busy", int'(rdata), 0);
        we = 1; addr = ADDR_W'(5); wdata = 8'hAA; recall_req = 1;
      end
      if (poke && len == 3) begin
        we = 0; recall_req = 0;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int len;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 busy after reset", int'(busy), 0);
    rst_n = 1;
    read_all("R1 reset contents", 0, 1);

    write_all(0);
    read_all("R2 host write/read", 0, 0);

    run_op(1, 0, 1, len);
    chk("R4 store busy length", len, STORE_LEN);
    chk("R3 store accepted", int'(len > 0), 1);
    @(negedge clk);
    chk("R10 request during busy dropped", int'(busy), 0);
    read_all("R5 write during busy ignored", 0, 0);

    write_all(1);
    read_all("R2 overwrite", 1, 0);
    run_op(0, 1, 0, len);
    chk("R4 recall busy length", len, RECALL_LEN);
    read_all("R6 recall restores shadow", 0, 0);

    write_all(1);
    run_op(0, 1, 0, len);
    read_all("R7 repeated recall", 0, 0);

    low_volt = 1;
    write_all(2);
    read_all("R8 write ignored low voltage", 0, 0);
    run_op(1, 0, 0, len);
    chk("R8 store refused low voltage", len, 0);
    run_op(0, 1, 0, len);
    chk("R9 recall under low voltage", len, RECALL_LEN);
    read_all("R9 recall data under low voltage", 0, 0);
    low_volt = 0;

    write_all(3);
    run_op(1, 1, 0, len);
    chk("R11 tie runs store", len, STORE_LEN);
    @(negedge clk);
    chk("R11 recall of tie dropped", int'(busy), 0);
    write_all(1);
    run_op(0, 1, 0, len);
    read_all("R11 shadow holds store data", 3, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule